// File: doc/BRIEF.md
# Serial Successive-Approximation Converter Controller

This block is the digital half of a bit-serial successive-approximation analog-to-digital converter. A host selects the block by pulling an active-low select line low and then supplies a serial clock. In the addressed variant the host first sends a start marker followed by a two-bit input-assignment word on the serial data input. The block decodes that word into select and polarity lines for an external analog multiplexer, reserves one clock period for the analog path to settle, and then walks a trial code through a successive-approximation search. It consults a single-bit comparator input once per step.

Each decided bit appears on the serial data pin in the same period in which the comparator decides it, most significant bit first. The addressed variant then sends the result again, least significant bit first, without repeating the shared least significant bit. The data pin is tri-state, and the block drives it only while it has something to say. This lets a host tie the data input and the data output to one bidirectional wire. A parameter selects a fixed-input variant instead. That variant has no addressing phase and no reversed replay.

The comparator, the resistor ladder and the multiplexer are outside the block. The trial code leaves the block as a parallel bus for the ladder, and the comparator decision returns as a plain input.

Top module: `sar_adc_ctl`

## Requirements
- R1: While rst_n is low, or on any rising clock edge with cs_n high, the block clears its state: dac_code becomes 0 and mux_valid becomes 0. sdo_en is 0 and sdo_pin is high impedance at once whenever cs_n is high, without waiting for an edge.
- R2: In the addressed variant (ADDR_EN=1) the block ignores din samples of 0 taken after cs_n falls. The first rising edge that samples din=1 takes the start marker, even when it is the very first edge after selection.
- R3: The two rising edges after the start marker sample the single-ended flag (1 = single-ended), then the odd flag. mux_pos_ch equals the odd flag (0 = CH0 is the positive input, 1 = CH1). mux_neg_gnd equals the single-ended flag (1 = negative input is ground, 0 = the other channel). Both are valid while mux_valid is 1.
- R4: The period after the edge that samples the odd flag is the settling slot. In it sdo_en is 1, sdo_pin is 0, mux_valid is 1 and dac_code is 1 in its most significant bit only (0x80 for WIDTH=8).
- R5: WIDTH conversion periods follow the settling slot, for bits WIDTH-1 down to 0. In the period for bit j, dac_code holds the decided upper bits with bit j set and all lower bits clear, and sdo_pin follows cmp_in. At the edge that ends the period, bit j keeps the cmp_in value (1 means input is at least the trial code) and the bit below is set. After the last step dac_code holds the result.
- R6: In the addressed variant, WIDTH-1 replay periods follow the conversion. They carry result bits 1 up to WIDTH-1 on sdo_pin, one per period, with mux_valid 0 and dac_code holding the result.
- R7: din has no effect from the settling slot until cs_n rises. A 1 on din then neither restarts addressing nor changes the mux lines.
- R8: After the last data period sdo_en returns to 0 while cs_n is still low. Further clocks leave all outputs unchanged until cs_n goes high and low again.
- R9: When the negative input exceeds the positive input the comparator never reports 1, and the result is all zeros.
- R10: In the fixed variant (ADDR_EN=0) the first rising edge with cs_n low starts the settling slot. mux_pos_ch is 0 and mux_neg_gnd is 0. sdo_en falls right after the bit 0 period, with no replay.
- R11: Raising cs_n in the middle of a conversion abandons it. A new selection then runs a complete, correct transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high clears the transaction |
| din | input | 1 | Serial address input, sampled on rising edges |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at least the trial code |
| dac_code | output | WIDTH | Trial code for the external ladder |
| mux_valid | output | 1 | Mux lines are meaningful (settling slot and conversion) |
| mux_pos_ch | output | 1 | Channel routed to the positive comparator input |
| mux_neg_gnd | output | 1 | Negative comparator input tied to ground |
| sdo_en | output | 1 | Data pin driver enable |
| sdo_pin | output | 1 | Tri-state serial data output |

## Verification
A corrupted phase shows at the pins within one period. sdo_en rises or falls on the wrong edge, mux_valid opens or closes early, or dac_code stops presenting the single trailing set bit that each search step needs. A wrong trial register shows on dac_code in the step where it goes wrong, and again on sdo_pin one step later, because the external comparator then answers against the wrong code. An error in the replay index or the address capture shows on sdo_pin in the affected replay period or on the mux lines from the settling slot onward. A missed clear shows as a nonzero dac_code on the first edge after selection is dropped.

// File: rtl/sar_adc_ctl_pkg.sv
package sar_adc_ctl_pkg;

   // transaction phases, in the order they occur
   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_ADDR   = 3'd1,
      PH_SETTLE = 3'd2,
      PH_CONV   = 3'd3,
      PH_REPLAY = 3'd4,
      PH_DONE   = 3'd5
   } sar_phase_e;

   // number of assignment bits following the start marker
   localparam int unsigned ASSIGN_BITS = 2;

   typedef struct packed {
      logic pos_ch;   // 0: CH0 positive, 1: CH1 positive
      logic neg_gnd;  // 1: negative input grounded
   } mux_sel_t;

   function automatic mux_sel_t mux_decode(input logic single, input logic odd);
      mux_sel_t s;
      s.pos_ch  = odd;
      s.neg_gnd = single;
      return s;
   endfunction

endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
   import sar_adc_ctl_pkg::*;
#(
   parameter int WIDTH     = 8,
   parameter int ADDR_EN   = 1,
   parameter int REPLAY_EN = 1,
   parameter int IW        = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          din,
   output sar_phase_e    phase,
   output logic [IW-1:0] idx,
   output logic          load_trial
);

   localparam logic [IW-1:0] TOP_IDX     = IW'(WIDTH - 1);
   localparam logic [IW-1:0] LAST_ASSIGN = IW'(ASSIGN_BITS - 1);

   sar_phase_e    ph_q, ph_n;
   logic [IW-1:0] idx_q, idx_n;

   always_comb begin
      ph_n  = ph_q;
      idx_n = idx_q;
      case (ph_q)
         PH_IDLE: begin
            if (ADDR_EN == 0) begin
               ph_n = PH_SETTLE;
            end else if (din) begin
               ph_n  = PH_ADDR;
               idx_n = '0;
            end
         end
         PH_ADDR: begin
            if (idx_q == LAST_ASSIGN) ph_n = PH_SETTLE;
            else                      idx_n = idx_q + IW'(1);
         end
         PH_SETTLE: begin
            ph_n  = PH_CONV;
            idx_n = TOP_IDX;
         end
         PH_CONV: begin
            if (idx_q != '0) begin
               idx_n = idx_q - IW'(1);
            end else if (REPLAY_EN != 0) begin
               ph_n  = PH_REPLAY;
               idx_n = IW'(1);
            end else begin
               ph_n = PH_DONE;
            end
         end
         PH_REPLAY: begin
            if (idx_q == TOP_IDX) ph_n = PH_DONE;
            else                  idx_n = idx_q + IW'(1);
         end
         PH_DONE: ph_n = PH_DONE;
         default: ph_n = PH_IDLE;
      endcase
      if (cs_n) begin
         ph_n  = PH_IDLE;
         idx_n = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         idx_q <= '0;
      end else begin
         ph_q  <= ph_n;
         idx_q <= idx_n;
      end
   end

   assign phase      = ph_q;
   assign idx        = idx_q;
   assign load_trial = (ph_n == PH_SETTLE) && (ph_q != PH_SETTLE);

endmodule

// File: rtl/sar_adc_addr.sv
module sar_adc_addr
   import sar_adc_ctl_pkg::*;
#(
   parameter int ADDR_EN = 1,
   parameter int IW      = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          din,
   input  sar_phase_e    phase,
   input  logic [IW-1:0] idx,
   output logic          pos_ch,
   output logic          neg_gnd
);

   mux_sel_t sel;

   generate
      if (ADDR_EN != 0) begin : g_addressed
         logic single_q, odd_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               single_q <= 1'b0;
               odd_q    <= 1'b0;
            end else if (cs_n) begin
               single_q <= 1'b0;
               odd_q    <= 1'b0;
            end else if (phase == PH_ADDR) begin
               if (idx == IW'(0)) single_q <= din;
               if (idx == IW'(1)) odd_q    <= din;
            end
         end

         assign sel = mux_decode(single_q, odd_q);
      end else begin : g_fixed
         logic unused_addr_in;
         assign unused_addr_in = ^{clk, rst_n, cs_n, din, phase, idx};
         // fixed input pair: CH0 positive against CH1
         assign sel = mux_decode(1'b0, 1'b0);
      end
   endgenerate

   assign pos_ch  = sel.pos_ch;
   assign neg_gnd = sel.neg_gnd;

endmodule

// File: rtl/sar_adc_trial.sv
module sar_adc_trial #(
   parameter int WIDTH = 8,
   parameter int IW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic             step,
   input  logic [IW-1:0]    idx,
   input  logic             cmp_in,
   output logic [WIDTH-1:0] code
);

   localparam logic [WIDTH-1:0] FIRST_TRIAL = {1'b1, {(WIDTH-1){1'b0}}};

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic decide_here, set_here;

         assign decide_here = step && (idx == IW'(b));
         if (b < WIDTH - 1) begin : g_below
            assign set_here = step && (idx == IW'(b + 1));
         end else begin : g_top
            assign set_here = 1'b0;
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           code[b] <= 1'b0;
            else if (clr)         code[b] <= 1'b0;
            else if (load)        code[b] <= FIRST_TRIAL[b];
            else if (decide_here) code[b] <= cmp_in;
            else if (set_here)    code[b] <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/sar_adc_dout.sv
module sar_adc_dout
   import sar_adc_ctl_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int IW    = 3
) (
   input  logic             cs_n,
   input  sar_phase_e       phase,
   input  logic [IW-1:0]    idx,
   input  logic [WIDTH-1:0] code,
   input  logic             cmp_in,
   output logic             drive,
   output logic             value
);

   always_comb begin
      case (phase)
         PH_CONV:   value = cmp_in;
         PH_REPLAY: value = code[idx];
         default:   value = 1'b0;
      endcase
   end

   assign drive = !cs_n &&
                  ((phase == PH_SETTLE) || (phase == PH_CONV) || (phase == PH_REPLAY));

endmodule

// File: rtl/sar_adc_ctl.sv
module sar_adc_ctl
   import sar_adc_ctl_pkg::*;
#(
   parameter int WIDTH   = 8,
   parameter int ADDR_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             din,
   input  logic             cmp_in,
   output logic [WIDTH-1:0] dac_code,
   output logic             mux_valid,
   output logic             mux_pos_ch,
   output logic             mux_neg_gnd,
   output logic             sdo_en,
   output wire              sdo_pin
);

   localparam int IW        = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int REPLAY_EN = ADDR_EN;

   generate
      if (WIDTH < 2 || WIDTH > 16) begin : g_bad_width
         $error("sar_adc_ctl: WIDTH must lie in 2..16");
      end
      if (ADDR_EN != 0 && ADDR_EN != 1) begin : g_bad_mode
         $error("sar_adc_ctl: ADDR_EN must be 0 or 1");
      end
   endgenerate

   sar_phase_e    phase;
   logic [IW-1:0] idx;
   logic          load_trial;
   logic          sdo_val;

   sar_adc_seq #(
      .WIDTH(WIDTH), .ADDR_EN(ADDR_EN), .REPLAY_EN(REPLAY_EN), .IW(IW)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
      .phase(phase), .idx(idx), .load_trial(load_trial)
   );

   sar_adc_addr #(.ADDR_EN(ADDR_EN), .IW(IW)) u_addr (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
      .phase(phase), .idx(idx),
      .pos_ch(mux_pos_ch), .neg_gnd(mux_neg_gnd)
   );

   sar_adc_trial #(.WIDTH(WIDTH), .IW(IW)) u_trial (
      .clk(clk), .rst_n(rst_n), .clr(cs_n), .load(load_trial),
      .step((phase == PH_CONV) && !cs_n), .idx(idx), .cmp_in(cmp_in),
      .code(dac_code)
   );

   sar_adc_dout #(.WIDTH(WIDTH), .IW(IW)) u_dout (
      .cs_n(cs_n), .phase(phase), .idx(idx), .code(dac_code), .cmp_in(cmp_in),
      .drive(sdo_en), .value(sdo_val)
   );

   assign mux_valid = !cs_n && ((phase == PH_SETTLE) || (phase == PH_CONV));
   assign sdo_pin   = sdo_en ? sdo_val : 1'bz;

endmodule

// File: rtl/sar_adc_ctl_chk.sv
module sar_adc_ctl_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic [WIDTH-1:0] dac_code,
   input logic             mux_valid,
   input logic             mux_pos_ch,
   input logic             mux_neg_gnd,
   input logic             sdo_en,
   input logic             sdo_pin
);

   localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

   // R1
   cs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> (dac_code == '0 && !mux_valid));

   // R4
   settle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_en) |-> (sdo_pin == 1'b0 && dac_code == MSB_ONLY && mux_valid));

   // R7
   mux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mux_valid |=> (cs_n || !mux_valid || ($stable(mux_pos_ch) && $stable(mux_neg_gnd))));

   // R6
   replay_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_en && !mux_valid && !cs_n) |=> (cs_n || $stable(dac_code)));

   // R8
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sdo_en) && !cs_n) |=> (cs_n || !sdo_en));

endmodule

bind sar_adc_ctl sar_adc_ctl_chk #(.WIDTH(WIDTH)) u_sar_adc_ctl_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dac_code(dac_code),
   .mux_valid(mux_valid), .mux_pos_ch(mux_pos_ch), .mux_neg_gnd(mux_neg_gnd),
   .sdo_en(sdo_en), .sdo_pin(sdo_pin)
);

// File: tb/test_sar_adc_ctl.sv
module test_sar_adc_ctl;

   localparam int CLK_PERIOD = 10;
   localparam int W          = 8;

   typedef struct packed {
      logic         en;
      logic         val;
      logic [W-1:0] dac;
      logic         mv;
      logic         pc;
      logic         ng;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   nchecks = 0;
   int   nerr = 0;
   bit   finished = 1'b0;
   int   ch0_v = 0;
   int   ch1_v = 0;

   // addressed instance signals
   logic         cs_a = 1'b1, din_a = 1'b0, cmp_a;
   logic [W-1:0] dac_a;
   logic         mv_a, pc_a, ng_a, en_a;
   wire          pin_a;
   // fixed instance signals
   logic         cs_f = 1'b1, din_f = 1'b0, cmp_f;
   logic [W-1:0] dac_f;
   logic         mv_f, pc_f, ng_f, en_f;
   wire          pin_f;

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural comparator and multiplexer
   function automatic logic cmp_model(logic [W-1:0] code, logic pos_ch, logic neg_gnd,
                                      logic valid, int a0, int a1);
      int p, n;
      p = pos_ch ? a1 : a0;
      n = neg_gnd ? 0 : (pos_ch ? a0 : a1);
      return valid && ((p - n) >= int'(code));
   endfunction

   always_comb cmp_a = cmp_model(dac_a, pc_a, ng_a, mv_a, ch0_v, ch1_v);
   always_comb cmp_f = cmp_model(dac_f, pc_f, ng_f, mv_f, ch0_v, ch1_v);

   sar_adc_ctl #(.WIDTH(W), .ADDR_EN(1)) i_sar_adc_ctl (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_a), .din(din_a), .cmp_in(cmp_a),
      .dac_code(dac_a), .mux_valid(mv_a), .mux_pos_ch(pc_a), .mux_neg_gnd(ng_a),
      .sdo_en(en_a), .sdo_pin(pin_a)
   );

   sar_adc_ctl #(.WIDTH(W), .ADDR_EN(0)) i_sar_adc_ctl_fixed (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_f), .din(din_f), .cmp_in(cmp_f),
      .dac_code(dac_f), .mux_valid(mv_f), .mux_pos_ch(pc_f), .mux_neg_gnd(ng_f),
      .sdo_en(en_f), .sdo_pin(pin_f)
   );

   function automatic exp_t mk(logic en, logic val, int dac, logic mv, logic pc, logic ng);
      exp_t e;
      e.en = en; e.val = val; e.dac = W'(dac); e.mv = mv; e.pc = pc; e.ng = ng;
      return e;
   endfunction

   // expected result from the input assignment and the analog values
   function automatic int exp_result(bit single, bit odd, bit fx, int a0, int a1);
      int d;
      if (fx)          d = a0 - a1;
      else if (single) d = odd ? a1 : a0;
      else             d = odd ? (a1 - a0) : (a0 - a1);
      if (d < 0)           d = 0;
      if (d > (1 << W) - 1) d = (1 << W) - 1;
      return d;
   endfunction

   function automatic int trial_of(int res, int j);
      return ((res >> (j + 1)) << (j + 1)) | (1 << j);
   endfunction

   task automatic chk(string tag, string what, int act, int expv);
      nchecks++;
      if (act != expv) begin
         nerr++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
      end
   endtask

   task automatic check_outs(bit fx, exp_t e, string tag);
      logic en, pin, mv, pc, ng;
      logic [W-1:0] dac;
      en  = fx ? en_f  : en_a;
      pin = fx ? pin_f : pin_a;
      mv  = fx ? mv_f  : mv_a;
      pc  = fx ? pc_f  : pc_a;
      ng  = fx ? ng_f  : ng_a;
      dac = fx ? dac_f : dac_a;
      chk(tag, "sdo_en", int'(en), int'(e.en));
      if (e.en) chk(tag, "sdo_pin", int'(pin), int'(e.val));
      chk(tag, "dac_code", int'(dac), int'(e.dac));
      chk(tag, "mux_valid", int'(mv), int'(e.mv));
      if (e.mv) begin
         chk(tag, "mux_pos_ch", int'(pc), int'(e.pc));
         chk(tag, "mux_neg_gnd", int'(ng), int'(e.ng));
      end
   endtask

   // one period: drive din, let one rising edge pass, compare at the falling edge
   task automatic step(bit fx, logic d, exp_t e, string tag);
      if (fx) din_f = d; else din_a = d;
      @(posedge clk);
      @(negedge clk);
      check_outs(fx, e, tag);
   endtask

   task automatic deselect(bit fx, int held, string tag);
      if (fx) cs_f = 1'b1; else cs_a = 1'b1;
      #1;
      check_outs(fx, mk(0, 0, held, 0, 0, 0), tag);
      step(fx, 1'b0, mk(0, 0, 0, 0, 0, 0), tag);
   endtask

   task automatic run_addr(bit single, bit odd, int lead, int a0, int a1, string rtag);
      int res;
      ch0_v = a0; ch1_v = a1;
      res = exp_result(single, odd, 1'b0, a0, a1);
      cs_a = 1'b0;
      #1;
      check_outs(0, mk(0, 0, 0, 0, 0, 0), "R2");
      for (int k = 0; k < lead; k++) step(0, 1'b0, mk(0, 0, 0, 0, 0, 0), "R2");
      step(0, 1'b1, mk(0, 0, 0, 0, 0, 0), "R2");
      step(0, single, mk(0, 0, 0, 0, 0, 0), "R3");
      step(0, odd, mk(1, 0, 1 << (W - 1), 1, odd, single), "R4");
      for (int j = W - 1; j >= 0; j--) begin
         // din toggles during the conversion; R7 says it has no effect
         step(0, logic'(j % 2 == 1), mk(1, (res >> j) & 1, trial_of(res, j), 1, odd, single),
              (j == W - 1) ? "R7" : rtag);
      end
      for (int i = 1; i < W; i++) begin
         step(0, 1'b1, mk(1, (res >> i) & 1, res, 0, 0, 0), "R6");
      end
      for (int k = 0; k < 3; k++) step(0, 1'b1, mk(0, 0, res, 0, 0, 0), "R8");
      deselect(0, res, "R1");
   endtask

   task automatic run_fixed(int a0, int a1);
      int res;
      ch0_v = a0; ch1_v = a1;
      res = exp_result(1'b0, 1'b0, 1'b1, a0, a1);
      cs_f = 1'b0;
      #1;
      check_outs(1, mk(0, 0, 0, 0, 0, 0), "R10");
      step(1, 1'b1, mk(1, 0, 1 << (W - 1), 1, 0, 0), "R10");
      for (int j = W - 1; j >= 0; j--) begin
         step(1, 1'b1, mk(1, (res >> j) & 1, trial_of(res, j), 1, 0, 0), "R10");
      end
      step(1, 1'b0, mk(0, 0, res, 0, 0, 0), "R10");
      for (int k = 0; k < 2; k++) step(1, 1'b1, mk(0, 0, res, 0, 0, 0), "R8");
      deselect(1, res, "R1");
   endtask

   task automatic run_abort();
      int res;
      ch0_v = 100; ch1_v = 0;
      res = exp_result(1'b1, 1'b0, 1'b0, 100, 0);
      cs_a = 1'b0;
      step(0, 1'b1, mk(0, 0, 0, 0, 0, 0), "R11");
      step(0, 1'b1, mk(0, 0, 0, 0, 0, 0), "R11");
      step(0, 1'b0, mk(1, 0, 1 << (W - 1), 1, 0, 1), "R11");
      for (int j = W - 1; j >= W - 3; j--) begin
         step(0, 1'b0, mk(1, (res >> j) & 1, trial_of(res, j), 1, 0, 1), "R11");
      end
      deselect(0, trial_of(res, W - 3), "R11");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_outs(0, mk(0, 0, 0, 0, 0, 0), "R1");
      check_outs(1, mk(0, 0, 0, 0, 0, 0), "R1");
      rst_n = 1'b1;
      step(0, 1'b1, mk(0, 0, 0, 0, 0, 0), "R1");   // din high while deselected
      run_addr(1'b1, 1'b0, 0, 200, 50, "R5");      // single-ended CH0
      run_addr(1'b1, 1'b1, 3, 10, 77, "R5");       // single-ended CH1, late start
      run_addr(1'b0, 1'b0, 1, 180, 60, "R5");      // differential CH0-CH1
      run_addr(1'b0, 1'b1, 2, 180, 60, "R9");      // negative beyond positive
      run_addr(1'b0, 1'b1, 0, 5, 300, "R5");       // above full scale
      run_addr(1'b1, 1'b0, 0, 0, 90, "R9");        // zero input
      run_abort();
      run_addr(1'b0, 1'b1, 0, 30, 115, "R11");     // recovery after abort
      run_fixed(150, 20);
      run_fixed(20, 150);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchecks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         nerr++;
         nchecks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchecks);
         $finish;
      end
   end

endmodule